// File: doc/BRIEF.md
# Indexed Color Palette with Host Register Port

This block is a color lookup table of 256 entries, each holding an 8-bit red, green and blue value. A host reaches it through a small register port. A two-bit select picks the index register, the color data register or the control port. All host data rides in the most significant byte of a 32-bit bus word.

The host loads an entry by writing its index and then writing three components in order. The entry is written to storage as a whole when the third component arrives. After that the index moves on to the next entry, so a run of entries can be streamed without rewriting the index.

Reads of the color data register follow the same component order and the same index advance. The index register also acts as an indirect pointer to four control registers: a pixel read mask, a blink mask, a command register and a test register. Bits 1:0 of the command register drive the cursor enable. On the video side an 8-bit pixel index is ANDed with the read mask and looked up, and the 24-bit color appears one clock later.

Top module: `clut_top`

## Requirements
- R1: A host write with select 0 loads the index from bus bits 31:24 and returns the component pointer to red. A host read with select 0 returns the index in bits 31:24 with all lower bits zero.
- R2: Host writes with select 1 take red, then green, then blue, each from bits 31:24. Red and green are staged. The stored entry changes only when blue is written, and then all three components are written together.
- R3: After a blue write or a blue read on select 1, the index increases by one, wrapping from 255 to 0, and the pointer returns to red.
- R4: A host read with select 1 returns the current component of the entry at the index in bits 31:24, with the lower bits zero. host_rdata updates on the clock edge that samples host_rd and holds until the next read.
- R5: Select 2 reaches the control register whose number is in the index register. Number 4 is the read mask and resets to 0xFF. Number 5 is the blink mask and resets to 0x00. Number 6 is the command register and resets to 0x73. Number 7 is the test register and resets to 0x00. With any other index number, a select 2 write changes nothing and a select 2 read returns zero.
- R6: cursor_en always equals bits 1:0 of the command register, so it is 2'b11 after reset.
- R7: pix_rgb shows the entry at (pix_idx AND read mask) one clock after pix_idx is sampled. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R8: Select 3 is reserved. A write with select 3 has no effect, and a read with select 3 returns zero.
- R9: Reset clears the index to 0, sets the pointer to red and sets host_rdata and pix_rgb to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 index, 1 color data, 2 control, 3 reserved |
| host_wr | input | 1 | Host write strobe, takes priority over host_rd |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write word; data in bits 31:24 |
| host_rdata | output | 32 | Registered host read word; data in bits 31:24 |
| pix_idx | input | 8 | Pixel color index |
| pix_rgb | output | 24 | Looked-up color, registered |
| cursor_en | output | 2 | Cursor enable bits from the command register |

## Verification
A component pointer that is out of step shows on the very next color read: the returned byte is another component of the same entry. An index that stepped wrongly shows on the next index read, or as the wrong entry on the pixel port one clock after lookup. Staging that commits too early is caught by writing only red and then reading the entry back. Any slip in control register decode shows at once on cursor_en or on a control read at a neighbouring index.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COLOR = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_RSVD  = 2'd3
    } host_sel_e;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_e;

    // control registers occupy index numbers CTRL_BASE .. CTRL_BASE+CTRL_NUM-1
    localparam int CTRL_BASE  = 4;
    localparam int CTRL_NUM   = 4;
    localparam int CTRL_RMASK = 0;
    localparam int CTRL_CMD   = 2;

    function automatic logic [7:0] ctrl_reset(input int k);
        case (k)
            CTRL_RMASK: ctrl_reset = 8'hFF;
            CTRL_CMD:   ctrl_reset = 8'h73;
            default:    ctrl_reset = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clut_host_seq.sv
module clut_host_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          host_sel,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [BUS_W-1:0]    host_wdata,
    output logic [BUS_W-1:0]    host_rdata,
    input  logic [3*COMP_W-1:0] ent_rgb,
    output logic [IDX_W-1:0]    cur_idx,
    output logic [1:0]          cur_comp,
    output logic                wr_en,
    output logic [3*COMP_W-1:0] wr_rgb,
    output logic [IDX_W-1:0]    read_mask,
    output logic [1:0]          cursor_en
);

    localparam int CK_W = $clog2(CTRL_NUM);

    typedef struct packed {
        logic [IDX_W-1:0]                 idx;
        comp_e                            comp;
        logic [2*COMP_W-1:0]              stage;
        logic [CTRL_NUM-1:0][COMP_W-1:0]  ctrl;
        logic [BUS_W-1:0]                 rdata;
    } seq_t;

    seq_t q, d;

    logic [COMP_W-1:0] lane;
    logic [IDX_W-1:0]  rel;
    logic              ctrl_hit;
    logic [CK_W-1:0]   ck;
    logic [COMP_W-1:0] comp_val;
    logic              unused_low;

    assign lane       = host_wdata[BUS_W-1 -: COMP_W];
    assign unused_low = ^host_wdata[BUS_W-COMP_W-1:0];
    assign rel        = q.idx - IDX_W'(CTRL_BASE);
    assign ctrl_hit   = rel < IDX_W'(CTRL_NUM);
    assign ck         = rel[CK_W-1:0];

    always_comb begin
        case (q.comp)
            COMP_R:  comp_val = ent_rgb[3*COMP_W-1 -: COMP_W];
            COMP_G:  comp_val = ent_rgb[2*COMP_W-1 -: COMP_W];
            default: comp_val = ent_rgb[COMP_W-1:0];
        endcase
    end

    always_comb begin
        d      = q;
        wr_en  = 1'b0;
        wr_rgb = {q.stage, lane};
        if (host_wr) begin
            case (host_sel)
                SEL_ADDR: begin
                    d.idx  = host_wdata[BUS_W-1 -: IDX_W];
                    d.comp = COMP_R;
                end
                SEL_COLOR: begin
                    case (q.comp)
                        COMP_R: begin
                            d.stage[2*COMP_W-1 -: COMP_W] = lane;
                            d.comp = COMP_G;
                        end
                        COMP_G: begin
                            d.stage[COMP_W-1:0] = lane;
                            d.comp = COMP_B;
                        end
                        default: begin
                            wr_en  = 1'b1;
                            d.idx  = q.idx + 1'b1;
                            d.comp = COMP_R;
                        end
                    endcase
                end
                SEL_CTRL: begin
                    if (ctrl_hit) d.ctrl[ck] = lane;
                end
                default: ;
            endcase
        end else if (host_rd) begin
            d.rdata = '0;
            case (host_sel)
                SEL_ADDR: d.rdata[BUS_W-1 -: IDX_W] = q.idx;
                SEL_COLOR: begin
                    d.rdata[BUS_W-1 -: COMP_W] = comp_val;
                    case (q.comp)
                        COMP_R: d.comp = COMP_G;
                        COMP_G: d.comp = COMP_B;
                        default: begin
                            d.idx  = q.idx + 1'b1;
                            d.comp = COMP_R;
                        end
                    endcase
                end
                SEL_CTRL: begin
                    if (ctrl_hit) d.rdata[BUS_W-1 -: COMP_W] = q.ctrl[ck];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.idx   <= '0;
            q.comp  <= COMP_R;
            q.stage <= '0;
            q.rdata <= '0;
            for (int k = 0; k < CTRL_NUM; k++) begin
                q.ctrl[k] <= COMP_W'(ctrl_reset(k));
            end
        end else begin
            q <= d;
        end
    end

    assign host_rdata = q.rdata;
    assign cur_idx    = q.idx;
    assign cur_comp   = q.comp;
    assign read_mask  = q.ctrl[CTRL_RMASK][IDX_W-1:0];
    assign cursor_en  = q.ctrl[CTRL_CMD][1:0];

endmodule

// File: rtl/clut_store.sv
module clut_store #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [3*COMP_W-1:0] wr_rgb,
    input  logic [IDX_W-1:0]    host_idx,
    output logic [3*COMP_W-1:0] host_rgb,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int RGB_W = 3 * COMP_W;

    logic [RGB_W-1:0] mem [DEPTH];
    logic [RGB_W-1:0] pix_d, pix_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_rgb;
    end

    assign host_rgb = mem[host_idx];
    assign pix_d    = mem[pix_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign pix_rgb = pix_q;

endmodule

// File: rtl/clut_top.sv
module clut_top #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          host_sel,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [BUS_W-1:0]    host_wdata,
    output logic [BUS_W-1:0]    host_rdata,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb,
    output logic [1:0]          cursor_en
);

    logic [IDX_W-1:0]    cur_idx;
    logic [1:0]          cur_comp;
    logic                wr_en;
    logic [3*COMP_W-1:0] wr_rgb;
    logic [3*COMP_W-1:0] ent_rgb;
    logic [IDX_W-1:0]    read_mask;
    logic [IDX_W-1:0]    pix_masked;

    assign pix_masked = pix_idx & read_mask;

    clut_host_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_sel  (host_sel),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .ent_rgb   (ent_rgb),
        .cur_idx   (cur_idx),
        .cur_comp  (cur_comp),
        .wr_en     (wr_en),
        .wr_rgb    (wr_rgb),
        .read_mask (read_mask),
        .cursor_en (cursor_en)
    );

    clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (cur_idx),
        .wr_rgb  (wr_rgb),
        .host_idx(cur_idx),
        .host_rgb(ent_rgb),
        .pix_idx (pix_masked),
        .pix_rgb (pix_rgb)
    );

endmodule

// File: rtl/clut_chk.sv
module clut_chk #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       host_sel,
    input logic             host_wr,
    input logic             host_rd,
    input logic [BUS_W-1:0] host_wdata,
    input logic [BUS_W-1:0] host_rdata,
    input logic [IDX_W-1:0] cur_idx,
    input logic [1:0]       cur_comp
);

    // R1
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd0) |=>
            (cur_idx == $past(host_wdata[BUS_W-1 -: IDX_W]) && cur_comp == 2'd0));

    // R2
    comp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_comp != 2'd3);

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd1 && cur_comp == 2'd2) |=>
            (cur_idx == IDX_W'($past(cur_idx) + 1'b1) && cur_comp == 2'd0));

    // R4
    rdata_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> (host_rdata[BUS_W-COMP_W-1:0] == '0));

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_sel == 2'd3) |=> (host_rdata == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd) |=> ($stable(cur_idx) && $stable(cur_comp)));

endmodule

bind clut_top clut_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .cur_idx   (cur_idx),
    .cur_comp  (cur_comp)
);

// File: tb/clut_top_tb_top.sv
module clut_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [1:0]  cursor_en;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clut_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_sel  (host_sel),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .pix_idx   (pix_idx),
        .pix_rgb   (pix_rgb),
        .cursor_en (cursor_en)
    );

    // vector: [24:21] req, [20:19] sel, [18] wr, [17] rd, [16:9] byte, [8] check, [7:0] expected byte
    localparam int NV = 46;
    localparam logic [24:0] VEC [NV] = '{
        {4'd1, 2'd0, 1'b1, 1'b0, 8'h10, 1'b0, 8'h00}, // R1 index 0x10
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h11, 1'b0, 8'h00}, // R2 red
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h22, 1'b0, 8'h00}, // R2 green
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h33, 1'b0, 8'h00}, // R2 blue commits 0x10
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h44, 1'b0, 8'h00}, // R2 entry 0x11
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h55, 1'b0, 8'h00},
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h66, 1'b0, 8'h00},
        {4'd3, 2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h12}, // R3 index stepped twice
        {4'd1, 2'd0, 1'b1, 1'b0, 8'h10, 1'b0, 8'h00},
        {4'd4, 2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h11}, // R4 red
        {4'd4, 2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h22}, // R4 green
        {4'd4, 2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h33}, // R4 blue
        {4'd3, 2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h44}, // R3 read advanced index
        {4'd1, 2'd0, 1'b1, 1'b0, 8'h10, 1'b0, 8'h00},
        {4'd4, 2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h11},
        {4'd1, 2'd0, 1'b1, 1'b0, 8'h10, 1'b0, 8'h00}, // R1 pointer back to red
        {4'd1, 2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h11},
        {4'd3, 2'd0, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00}, // R3 wrap test
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h77, 1'b0, 8'h00},
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h88, 1'b0, 8'h00},
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h99, 1'b0, 8'h00},
        {4'd3, 2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00}, // R3 wrapped to 0
        {4'd5, 2'd0, 1'b1, 1'b0, 8'h04, 1'b0, 8'h00}, // R5 read mask
        {4'd5, 2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'hFF},
        {4'd5, 2'd0, 1'b1, 1'b0, 8'h05, 1'b0, 8'h00}, // R5 blink mask
        {4'd5, 2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00},
        {4'd5, 2'd0, 1'b1, 1'b0, 8'h06, 1'b0, 8'h00}, // R5 command
        {4'd5, 2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h73},
        {4'd5, 2'd0, 1'b1, 1'b0, 8'h07, 1'b0, 8'h00}, // R5 test
        {4'd5, 2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00},
        {4'd5, 2'd0, 1'b1, 1'b0, 8'h09, 1'b0, 8'h00}, // R5 out of range
        {4'd5, 2'd2, 1'b1, 1'b0, 8'hAB, 1'b0, 8'h00},
        {4'd5, 2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00},
        {4'd8, 2'd3, 1'b1, 1'b0, 8'h5A, 1'b0, 8'h00}, // R8 reserved write
        {4'd8, 2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h09},
        {4'd8, 2'd3, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00},
        {4'd5, 2'd0, 1'b1, 1'b0, 8'h04, 1'b0, 8'h00}, // R5 mask untouched
        {4'd5, 2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'hFF},
        {4'd2, 2'd0, 1'b1, 1'b0, 8'h20, 1'b0, 8'h00}, // R2 staging
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h01, 1'b0, 8'h00},
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h02, 1'b0, 8'h00},
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h03, 1'b0, 8'h00},
        {4'd2, 2'd0, 1'b1, 1'b0, 8'h20, 1'b0, 8'h00},
        {4'd2, 2'd1, 1'b1, 1'b0, 8'hEE, 1'b0, 8'h00}, // red only
        {4'd2, 2'd0, 1'b1, 1'b0, 8'h20, 1'b0, 8'h00},
        {4'd2, 2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h01}  // R2 entry not yet changed
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] sel, input logic wr, input logic rd, input logic [7:0] b);
        @(negedge clk);
        host_sel   = sel;
        host_wr    = wr;
        host_rd    = rd;
        host_wdata = {b, 24'h0};
        @(posedge clk);
        #1;
        host_wr = 1'b0;
        host_rd = 1'b0;
    endtask

    task automatic pix_step(input logic [7:0] idx);
        @(negedge clk);
        pix_idx = idx;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 rdata reset", host_rdata, 32'h0);
        check("R9 pix_rgb reset", {8'h0, pix_rgb}, 32'h0);
        check("R6 cursor_en reset", {30'h0, cursor_en}, 32'h3);
        op(2'd0, 1'b0, 1'b1, 8'h00);
        check("R9 index reset", host_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            op(v[20:19], v[18], v[17], v[16:9]);
            if (v[8]) check($sformatf("R%0d table vector %0d", v[24:21], i),
                            host_rdata, {v[7:0], 24'h0});
        end

        // R7 lookup and one-clock latency
        pix_step(8'h10);
        check("R7 entry 0x10", {8'h0, pix_rgb}, 32'h00112233);
        @(negedge clk);
        pix_idx = 8'h11;
        #1;
        check("R7 before edge", {8'h0, pix_rgb}, 32'h00112233);
        @(posedge clk);
        #1;
        check("R7 entry 0x11", {8'h0, pix_rgb}, 32'h00445566);
        pix_step(8'hFF);
        check("R7 entry 0xFF", {8'h0, pix_rgb}, 32'h00778899);

        // R7 read mask applied
        op(2'd0, 1'b1, 1'b0, 8'h01);
        op(2'd1, 1'b1, 1'b0, 8'hA0);
        op(2'd1, 1'b1, 1'b0, 8'hB0);
        op(2'd1, 1'b1, 1'b0, 8'hC0);
        op(2'd0, 1'b1, 1'b0, 8'h04);
        op(2'd2, 1'b1, 1'b0, 8'h0F);
        pix_step(8'hF1);
        check("R7 masked index", {8'h0, pix_rgb}, 32'h00A0B0C0);

        // R6 cursor enable follows command bits 1:0
        op(2'd0, 1'b1, 1'b0, 8'h06);
        op(2'd2, 1'b1, 1'b0, 8'h70);
        check("R6 cursor off", {30'h0, cursor_en}, 32'h0);
        op(2'd2, 1'b1, 1'b0, 8'h72);
        check("R6 cursor bit1", {30'h0, cursor_en}, 32'h2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule